// File: doc/BRIEF.md
# Distributed Rotating-Priority Bus Arbiter

This block decides which agent owns a shared external bus. Up to eight processor nodes and one host share that bus. No central arbiter exists. Each processor node runs an identical copy of this block. Every copy sees all request lines, the lock line and the host request, and every copy samples them on the same clock edge. Each copy therefore holds the same owner state, and only the copy whose strapped node number matches the current master raises its local grant.

Priority among the processor nodes rotates. When a new master must be chosen, the search starts at the node number after the most recent master and wraps from the highest number back to zero. The current master may assert the shared lock line to keep the bus through an indivisible read-modify-write sequence. Under contention, a programmable hold limit forces the master to give up the bus. A host request takes the bus away from the processors whenever no locked sequence is running, and the host keeps the bus until it drops its request.

Top module: `bus_arb_node`

## Requirements
- R1: During reset and on the first cycle after it, `master_valid_o`, `host_grant_o` and `grant_o` are low. The rotation pointer starts so that node 0 has the highest priority first.
- R2: `grant_o` is high exactly when a processor master exists and `master_id_o` equals `node_id_i`. Copies that receive the same inputs report the same owner, so at most one node sees its own grant.
- R3: When a new processor master is chosen, the winner is the first requesting node found by searching upward from the node after the last master, wrapping from NODES-1 to 0.
- R4: A master keeps the bus while it requests it and no other node requests it. When the master drops its request and nobody else requests, the bus becomes idle on the next cycle.
- R5: While other nodes request, a master holds the bus for at most `hold_limit_i` consecutive unlocked cycles, after which the rotating search picks another node. A limit of 0 acts as 1.
- R6: While a processor master exists and `lock_i` is high, that master keeps the bus on the next cycle whatever the request lines show, even its own. The hold count does not advance.
- R7: When `host_req_i` is high and no locked sequence is in progress, `host_grant_o` is high on the next cycle and no processor master exists. This continues while `host_req_i` stays high.
- R8: A host request made while a locked sequence is in progress is not granted until the lock drops.
- R9: After the host drops its request, processor arbitration resumes on the next cycle, with the search starting after the last processor master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all copies |
| rst | input | 1 | Synchronous active-high reset |
| node_id_i | input | IDW | Strapped number of this node |
| req_i | input | NODES | Bus request line of every processor node |
| lock_i | input | 1 | Lock line driven by the current master |
| host_req_i | input | 1 | Host bus request |
| hold_limit_i | input | CW | Maximum contended unlocked hold, in cycles |
| grant_o | output | 1 | This node owns the bus |
| host_grant_o | output | 1 | Host owns the bus |
| master_valid_o | output | 1 | A processor node owns the bus |
| master_id_o | output | IDW | Number of the owning processor node |

## Verification
The assertions check every cycle that a lock freezes the owner and blocks the host, that an unlocked host request wins on the next edge, that an expired hold under contention changes the owner, and that an idle request set empties the bus. The bench shows the behaviours that only emerge over a sequence of cycles. These are the rotating search order and its wrap, the exact hold length for each programmed limit, the pointer kept across a host tenure, and the agreement of eight copies with different strapped numbers. To check them, it compares all eight copies against a reference model of the requirements under random requests, locks, host traffic and limits.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;

    // Who owns the shared bus in the current cycle
    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_PROC = 2'd1,
        OWN_HOST = 2'd2
    } owner_e;

    // A programmed limit of zero behaves as a limit of one
    function automatic int unsigned eff_limit(input int unsigned lim);
        return (lim == 0) ? 1 : lim;
    endfunction

endpackage

// File: rtl/arb_rot_pick.sv
module arb_rot_pick #(
    parameter int unsigned NODES = 8,
    parameter int unsigned IDW   = $clog2(NODES)
) (
    input  logic [NODES-1:0] req_i,
    input  logic [IDW-1:0]   last_i,
    output logic             found_o,
    output logic [IDW-1:0]   win_o
);
    // Search offsets from far to near so the nearest requester after last_i wins
    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        for (int k = NODES; k >= 1; k--) begin
            int idx;
            idx = int'(last_i) + k;
            if (idx >= int'(NODES)) idx = idx - int'(NODES);
            if (req_i[idx]) begin
                found_o = 1'b1;
                win_o   = IDW'(idx);
            end
        end
    end
endmodule

// File: rtl/arb_hold_timer.sv
module arb_hold_timer #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          advance_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o
);
    import bus_arb_pkg::*;

    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= CW'(1);
        end else if (advance_i && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign expired_o = int'(cnt_q) >= int'(eff_limit(int'(limit_i)));

    // R6: the count is frozen on cycles that neither start nor advance it (locked)
    a_r6_count_frozen: assert property (@(posedge clk) disable iff (rst)
        (!start_i && !advance_i) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/bus_arb_node.sv
module bus_arb_node #(
    parameter int unsigned NODES = 8,
    parameter int unsigned IDW   = $clog2(NODES),
    parameter int unsigned CW    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDW-1:0]   node_id_i,
    input  logic [NODES-1:0] req_i,
    input  logic             lock_i,
    input  logic             host_req_i,
    input  logic [CW-1:0]    hold_limit_i,
    output logic             grant_o,
    output logic             host_grant_o,
    output logic             master_valid_o,
    output logic [IDW-1:0]   master_id_o
);
    import bus_arb_pkg::*;

    localparam logic [IDW-1:0] PTR_RESET = IDW'(NODES - 1);

    owner_e         owner_q, owner_d;
    logic [IDW-1:0] master_q, master_d;
    logic [IDW-1:0] last_q, last_d;

    logic           is_proc, locked, others_any, keep, expired;
    logic           pick_found, tmr_start, tmr_adv;
    logic [IDW-1:0] pick_win;
    logic [NODES-1:0] others_vec;

    assign is_proc    = (owner_q == OWN_PROC);
    assign locked     = is_proc && lock_i;
    assign others_vec = req_i & ~(NODES'(1) << master_q);
    assign others_any = |others_vec;
    assign keep       = is_proc && req_i[master_q] && (!others_any || !expired);

    arb_rot_pick #(.NODES(NODES), .IDW(IDW)) u_pick (
        .req_i   (req_i),
        .last_i  (last_q),
        .found_o (pick_found),
        .win_o   (pick_win)
    );

    arb_hold_timer #(.CW(CW)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start_i   (tmr_start),
        .advance_i (tmr_adv),
        .limit_i   (hold_limit_i),
        .expired_o (expired)
    );

    always_comb begin
        owner_d   = owner_q;
        master_d  = master_q;
        last_d    = last_q;
        tmr_start = 1'b0;
        tmr_adv   = 1'b0;
        if (locked) begin
            // atomic sequence: hold everything
        end else if (host_req_i) begin
            owner_d = OWN_HOST;
        end else if (keep) begin
            tmr_adv = 1'b1;
        end else if (pick_found) begin
            owner_d   = OWN_PROC;
            master_d  = pick_win;
            last_d    = pick_win;
            tmr_start = 1'b1;
        end else begin
            owner_d = OWN_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q  <= OWN_IDLE;
            master_q <= '0;
            last_q   <= PTR_RESET;
        end else begin
            owner_q  <= owner_d;
            master_q <= master_d;
            last_q   <= last_d;
        end
    end

    assign master_valid_o = is_proc;
    assign master_id_o    = master_q;
    assign host_grant_o   = (owner_q == OWN_HOST);
    assign grant_o        = is_proc && (master_q == node_id_i);

    // R1: nothing owns the bus right after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!master_valid_o && !host_grant_o && !grant_o));

    // R6: a locked master keeps the bus
    a_r6_lock_keeps: assert property (@(posedge clk) disable iff (rst)
        (is_proc && lock_i) |=> (master_valid_o && master_id_o == $past(master_id_o)));

    // R8: no host grant may follow a locked cycle
    a_r8_host_waits_lock: assert property (@(posedge clk) disable iff (rst)
        (is_proc && lock_i) |=> !host_grant_o);

    // R7: an unlocked host request wins on the next edge
    a_r7_host_wins: assert property (@(posedge clk) disable iff (rst)
        (host_req_i && !(is_proc && lock_i)) |=> (host_grant_o && !master_valid_o));

    // R5: an expired hold under contention hands the bus on
    a_r5_fair_release: assert property (@(posedge clk) disable iff (rst)
        (is_proc && !lock_i && !host_req_i && others_any && expired)
        |=> !(master_valid_o && master_id_o == $past(master_id_o)));

    // R4: with no request of any kind and no lock the bus goes idle
    a_r4_idle: assert property (@(posedge clk) disable iff (rst)
        (req_i == '0 && !host_req_i && !(is_proc && lock_i))
        |=> (!master_valid_o && !host_grant_o));
endmodule

// File: tb/bus_arb_node_tb_top.sv
module bus_arb_node_tb_top;
    localparam int NODES = 8;
    localparam int IDW   = 3;
    localparam int CW    = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NODES-1:0] req = '0;
    logic             lock = 1'b0;
    logic             host_req = 1'b0;
    logic [CW-1:0]    limit = CW'(4);

    logic [NODES-1:0] grant_v, hostg_v, mval_v;
    logic [IDW-1:0]   mid_v [NODES];

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit finished = 0;
    string cur_tag = "R2";

    // reference model of the requirements
    bit m_host, m_valid;
    int m_id, m_last, m_cnt;

    always #5 clk = ~clk;

    for (genvar g = 0; g < NODES; g++) begin : g_node
        bus_arb_node #(.NODES(NODES), .IDW(IDW), .CW(CW)) dut_i (
            .clk            (clk),
            .rst            (rst),
            .node_id_i      (IDW'(g)),
            .req_i          (req),
            .lock_i         (lock),
            .host_req_i     (host_req),
            .hold_limit_i   (limit),
            .grant_o        (grant_v[g]),
            .host_grant_o   (hostg_v[g]),
            .master_valid_o (mval_v[g]),
            .master_id_o    (mid_v[g])
        );
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_host = 0; m_valid = 0; m_id = 0; m_last = NODES - 1; m_cnt = 0;
    endtask

    function automatic int lim_eff();
        return (limit == 0) ? 1 : int'(limit);
    endfunction

    task automatic model_step();
        bit others, keep, found;
        int w;
        others = 0;
        for (int i = 0; i < NODES; i++) if (req[i] && !(m_valid && i == m_id)) others = 1;
        if (m_valid && lock) begin
            // frozen
        end else if (host_req) begin
            m_host = 1; m_valid = 0;
        end else begin
            m_host = 0;
            keep = m_valid && req[m_id] && (!others || m_cnt < lim_eff());
            if (keep) begin
                if (m_cnt < 15) m_cnt++;
            end else begin
                found = 0; w = 0;
                for (int k = 1; k <= NODES; k++) begin
                    int idx;
                    idx = (m_last + k) % NODES;
                    if (!found && req[idx]) begin found = 1; w = idx; end
                end
                if (found) begin
                    m_valid = 1; m_id = w; m_last = w; m_cnt = 1;
                end else begin
                    m_valid = 0;
                end
            end
        end
    endtask

    // compare all copies against the model (R2 for the grant agreement)
    task automatic compare_all();
        for (int i = 0; i < NODES; i++) begin
            check(mval_v[i] == m_valid, cur_tag, int'(mval_v[i]), int'(m_valid));
            check(hostg_v[i] == m_host, cur_tag, int'(hostg_v[i]), int'(m_host));
            if (m_valid)
                check(int'(mid_v[i]) == m_id, cur_tag, int'(mid_v[i]), m_id);
            check(grant_v[i] == (m_valid && m_id == i), "R2", int'(grant_v[i]),
                  int'(m_valid && m_id == i));
        end
        check($countones(grant_v) <= 1, "R2", $countones(grant_v), 1);
    endtask

    task automatic step(input logic [NODES-1:0] r, input bit lk, input bit hr);
        req = r; lock = lk; host_req = hr;
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: idle after reset
        check(mval_v == '0 && hostg_v == '0 && grant_v == '0, "R1", int'(mval_v), 0);

        // R3: a lone requester wins; R4: it keeps the bus, then idles
        cur_tag = "R3";
        step(8'h08, 0, 0);
        check(mval_v[0] && mid_v[0] == 3 && grant_v[3], "R3", int'(mid_v[0]), 3);
        cur_tag = "R4";
        for (int i = 0; i < 5; i++) step(8'h08, 0, 0);
        check(mid_v[5] == 3 && grant_v[3], "R4", int'(mid_v[5]), 3);
        step(8'h00, 0, 0);
        check(!mval_v[2], "R4", int'(mval_v[2]), 0);

        // R3: search after node 3 reaches 6 before 1
        cur_tag = "R3";
        step(8'h42, 0, 0);
        check(mid_v[1] == 6, "R3", int'(mid_v[1]), 6);

        // R5: limit 2 under contention, then wrap to node 1
        cur_tag = "R5";
        limit = CW'(2);
        step(8'h42, 0, 0);
        check(mid_v[0] == 6, "R5", int'(mid_v[0]), 6);
        step(8'h42, 0, 0);
        check(mid_v[0] == 1 && grant_v[1], "R5", int'(mid_v[0]), 1);

        // R6: lock holds node 1 even without its own request; R8: host waits
        cur_tag = "R6";
        for (int i = 0; i < 6; i++) step(8'h44, 1, (i >= 3));
        check(mid_v[4] == 1 && grant_v[1], "R6", int'(mid_v[4]), 1);
        check(!hostg_v[4], "R8", int'(hostg_v[4]), 0);

        // R7: lock dropped, host takes over and keeps it
        cur_tag = "R7";
        step(8'h05, 0, 1);
        check(hostg_v[0] && !mval_v[0], "R7", int'(hostg_v[0]), 1);
        step(8'h05, 0, 1);
        check(hostg_v[7] && grant_v == '0, "R7", int'(hostg_v[7]), 1);

        // R9: host gone, search resumes after node 1: node 2 before node 0
        cur_tag = "R9";
        step(8'h05, 0, 0);
        check(mval_v[6] && mid_v[6] == 2 && !hostg_v[6], "R9", int'(mid_v[6]), 2);

        // R5: limit 0 behaves as 1
        cur_tag = "R5";
        limit = CW'(0);
        step(8'h05, 0, 0);
        check(mid_v[3] == 0, "R5", int'(mid_v[3]), 0);

        // constrained random mix checked against the model
        cur_tag = "R2";
        void'($urandom(32'd1234));
        for (int n = 0; n < 3000; n++) begin
            logic [NODES-1:0] r;
            bit lk, hr;
            if (n % 200 == 0) limit = CW'($urandom_range(0, 5));
            r  = NODES'($urandom) & NODES'($urandom);
            lk = ($urandom_range(0, 5) == 0);
            hr = ($urandom_range(0, 9) == 0);
            step(r, lk, hr);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule